// File: doc/BRIEF.md
# GPIO Controller with Level-Match Interrupts

A 32-pin general-purpose I/O block. Software reaches it through six 32-bit registers on a simple write-strobe register bus, and it drives the pads through separate in, out and output-enable vectors. A per-pin function bit chooses who owns the pad. Under GPIO control, a direction bit and a data bit decide what the pad does. Under alternate control, a peripheral's signal drives the pad, with a direction that the hardware fixes for each pin. Only the lower fourteen pins have an alternate owner. On pins 0 to 3 that owner is a UART: serial out, serial in, request-to-send and clear-to-send.

Each pin is resynchronised by two flops. The synchronised value is compared with a programmed target level. While the two match, a sticky status bit is set. Software clears that bit by writing a one to it. Any status bit whose enable is also set raises a registered non-maskable interrupt line.

Reads are combinational from the word address. Writes take effect at the clock edge where the write strobe is high.

Top module: `gpio_lvl_top`

## Requirements
- R1: While reset is asserted, and directly after it, every register reads 0, pad_oe is 0 and nmi_o is 0.
- R2: Word offsets 0x00 (function select), 0x04 (direction), 0x0C (target level) and 0x14 (NMI enable) read back the last value written. Offsets 0x00 to 0x14 are decoded from bus_addr[4:2]. A write to a misaligned address (bus_addr[1:0] != 0) is ignored.
- R3: When a pin's function bit is 0, pad_oe[x] equals direction bit x, with 1 meaning output. In that case pad_out[x] equals bit x of the last value written to offset 0x08.
- R4: A read of offset 0x08 returns pad_in through a two-flop synchroniser, once pad_in has been held for 3 cycles.
- R5: Status bit x (offset 0x10) becomes 1 while synchronised pin x equals target level bit x. It then stays 1 until it is cleared.
- R6: Writing offset 0x10 clears the status bits written as 1 and leaves the bits written as 0 unchanged. If a match and a clear of the same bit occur in the same cycle, the bit stays 1.
- R7: nmi_o is 1 exactly when any (status AND enable) bit was 1 on the previous clock edge.
- R8: For pins 0 to 13 with the function bit set to 1, pad_out follows alt_tx. pad_oe is then fixed: 1 for pins 0, 2, 4, 5, 6, 7, 8 and 13 (mask 0x21F5), and 0 for pins 1, 3 and 9 to 12.
- R9: For pins 14 to 31, the function bit has no effect, and pad_oe and pad_out follow the GPIO registers.
- R10: alt_rx carries the synchronised pin values, whatever the function selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Pad input values |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables |
| alt_tx | input | 32 | Signals from the alternate peripherals |
| alt_rx | output | 32 | Synchronised pin values to the alternate peripherals |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The bench builds the block with its default parameters: 32 pins, a 5-bit byte address, the 14-pin alternate mask and the 0x21F5 fixed-direction mask. These defaults put both kinds of pin within reach: pins 0 to 13, which can be handed over, and pins 14 to 31, whose function bit must do nothing. Random pad values, target levels and clear masks exercise the sticky status accumulation. That includes the transient matches between an old pin value and a new level. Directed cases cover set-beats-clear, a full clear with no match, and the NMI falling once the status is clean.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  typedef enum logic [2:0] {
    SEL_FUNC = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_DATA = 3'd2,
    SEL_LVL  = 3'd3,
    SEL_STAT = 3'd4,
    SEL_NMIE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_val,
  input  logic [NPINS-1:0]  stat,
  output logic [NPINS-1:0]  func_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  lvl_q,
  output logic [NPINS-1:0]  nmie_q,
  output logic [NPINS-1:0]  clr_mask
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             we_func, we_dir, we_dout, we_lvl, we_nmie;
  logic [NPINS-1:0] func_d, dir_d, dout_d, lvl_d, nmie_d;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    we_func  = wr_en && aligned && (idx == IDX_W'(SEL_FUNC));
    we_dir   = wr_en && aligned && (idx == IDX_W'(SEL_DIR));
    we_dout  = wr_en && aligned && (idx == IDX_W'(SEL_DATA));
    we_lvl   = wr_en && aligned && (idx == IDX_W'(SEL_LVL));
    we_nmie  = wr_en && aligned && (idx == IDX_W'(SEL_NMIE));
    clr_mask = (wr_en && aligned && (idx == IDX_W'(SEL_STAT))) ? wdata : '0;
    func_d   = we_func ? wdata : func_q;
    dir_d    = we_dir  ? wdata : dir_q;
    dout_d   = we_dout ? wdata : dout_q;
    lvl_d    = we_lvl  ? wdata : lvl_q;
    nmie_d   = we_nmie ? wdata : nmie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      lvl_q  <= '0;
      nmie_q <= '0;
    end else begin
      func_q <= func_d;
      dir_q  <= dir_d;
      dout_q <= dout_d;
      lvl_q  <= lvl_d;
      nmie_q <= nmie_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(SEL_FUNC): rdata = func_q;
        IDX_W'(SEL_DIR):  rdata = dir_q;
        IDX_W'(SEL_DATA): rdata = pin_val;
        IDX_W'(SEL_LVL):  rdata = lvl_q;
        IDX_W'(SEL_STAT): rdata = stat;
        IDX_W'(SEL_NMIE): rdata = nmie_q;
        default:          rdata = '0;
      endcase
    end
  end

  // R2: the function register only changes on a decoded write to it
  a_r2_func_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && aligned && idx == IDX_W'(SEL_FUNC)) |=> $stable(func_q));
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_val,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] nmie,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] stat_q,
  output logic             nmi_q
);
  logic [NPINS-1:0] match_vec;
  logic [NPINS-1:0] stat_d;
  logic             nmi_d;

  always_comb begin
    match_vec = ~(pin_val ^ lvl);
    stat_d    = (stat_q & ~clr_mask) | match_vec;
    nmi_d     = |(stat_q & nmie);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      nmi_q  <= nmi_d;
    end
  end

  // R5: a set status bit only drops when a clear targeted it
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_mask)) & ~stat_q) == '0));
  // R6: a match in the clearing cycle keeps the bit set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pin_val ^ lvl) | stat_q) == '1));
  // R7: interrupt edges follow enabled status one cycle earlier
  a_r7_nmi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_q) |-> $past((stat_q & nmie) != '0));
  a_r7_nmi_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_q) |-> $past((stat_q & nmie) == '0));
endmodule

// File: rtl/gpio_lvl_padmux.sv
module gpio_lvl_padmux #(
  parameter int unsigned     NPINS       = 32,
  parameter logic [NPINS-1:0] ALT_PRESENT = 32'h0000_3FFF,
  parameter logic [NPINS-1:0] ALT_DIR     = 32'h0000_21F5
) (
  input  logic [NPINS-1:0] func,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] alt_tx,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic alt_sel;
    assign alt_sel    = func[i] & ALT_PRESENT[i];
    assign pad_out[i] = alt_sel ? alt_tx[i]  : dout[i];
    assign pad_oe[i]  = alt_sel ? ALT_DIR[i] : dir[i];
  end
endmodule

// File: rtl/gpio_lvl_top.sv
module gpio_lvl_top #(
  parameter int unsigned      NPINS       = 32,
  parameter int unsigned      ADDR_W      = 5,
  parameter logic [NPINS-1:0] ALT_PRESENT = 32'h0000_3FFF,
  parameter logic [NPINS-1:0] ALT_DIR     = 32'h0000_21F5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  alt_tx,
  output logic [NPINS-1:0]  alt_rx,
  output logic              nmi_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [NPINS-1:0] pin_val, stat, func, dir, dout, lvl, nmie, clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  gpio_lvl_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(pad_in), .q_o(pin_val));

  gpio_lvl_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .pin_val(pin_val), .stat(stat),
    .func_q(func), .dir_q(dir), .dout_q(dout), .lvl_q(lvl),
    .nmie_q(nmie), .clr_mask(clr_mask));

  gpio_lvl_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .pin_val(pin_val), .lvl(lvl),
    .nmie(nmie), .clr_mask(clr_mask), .stat_q(stat), .nmi_q(nmi_o));

  gpio_lvl_padmux #(.NPINS(NPINS), .ALT_PRESENT(ALT_PRESENT),
                    .ALT_DIR(ALT_DIR)) u_mux (
    .func(func), .dir(dir), .dout(dout), .alt_tx(alt_tx),
    .pad_out(pad_out), .pad_oe(pad_oe));

  assign alt_rx = pin_val;

  // R9: pins without an alternate owner always follow the GPIO registers
  a_r9_no_alt_upper: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((pad_oe & ~ALT_PRESENT) == (dir & ~ALT_PRESENT)) &&
    ((pad_out & ~ALT_PRESENT) == (dout & ~ALT_PRESENT)));
  // R8: handed-over pins take the fixed direction mask
  a_r8_fixed_dir: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((pad_oe ^ ALT_DIR) & func & ALT_PRESENT) == '0);
endmodule

// File: tb/sim_gpio_lvl_top.sv
`timescale 1ns/1ps
module sim_gpio_lvl_top;
  localparam logic [31:0] PRES = 32'h0000_3FFF;
  localparam logic [31:0] ODIR = (32'd1 << 0) | (32'd1 << 2) | (32'd1 << 4) |
                                 (32'd1 << 5) | (32'd1 << 6) | (32'd1 << 7) |
                                 (32'd1 << 8) | (32'd1 << 13);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, alt_rx;
  logic [31:0] alt_tx = '0;
  logic        nmi_o;

  int unsigned errors = 0;
  int unsigned checks = 0;
  bit          done = 1'b0;
  logic [31:0] exp_st, cur_pin, cur_lvl, cur_en, cur_func, cur_dir, cur_dout;
  logic [31:0] rd, seed_sink;

  always #4 clk = ~clk;

  gpio_lvl_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_tx(alt_tx), .alt_rx(alt_rx),
    .nmi_o(nmi_o));

  function automatic logic [31:0] exp_oe(logic [31:0] f, logic [31:0] d);
    logic [31:0] a = f & PRES;
    return (a & ODIR) | (~a & d);
  endfunction

  function automatic logic [31:0] exp_out(logic [31:0] f, logic [31:0] o,
                                          logic [31:0] t);
    logic [31:0] a = f & PRES;
    return (a & t) | (~a & o);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_level(input logic [31:0] l);
    wr(5'h0C, l);
    cur_lvl = l;
    exp_st  = exp_st | ~(cur_pin ^ cur_lvl);
  endtask

  task automatic set_pin(input logic [31:0] p);
    pad_in  = p;
    wait_cyc(4);
    cur_pin = p;
    exp_st  = exp_st | ~(cur_pin ^ cur_lvl);
  endtask

  task automatic clear_st(input logic [31:0] m);
    wr(5'h10, m);
    exp_st = (exp_st & ~m) | ~(cur_pin ^ cur_lvl);
    wait_cyc(1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    seed_sink = $urandom(32'h5EED_0042);
    exp_st = '0; cur_pin = '0; cur_lvl = '0; cur_en = '0;
    cur_func = '0; cur_dir = '0; cur_dout = '0;
    wait_cyc(5);
    // R1: reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 nmi", {31'd0, nmi_o}, 32'h0);
    for (int i = 0; i < 6; i++) begin
      rdreg(5'(i * 4), rd);
      chk("R1 reg", rd, 32'h0);
    end
    rst_n = 1'b1;
    wait_cyc(6);
    exp_st = exp_st | ~(cur_pin ^ cur_lvl);
    rdreg(5'h10, rd);
    chk("R5 match after reset", rd, exp_st);

    // R2: register readback and misaligned write
    cur_func = $urandom(); cur_dir = $urandom();
    wr(5'h00, cur_func); wr(5'h04, cur_dir);
    set_level($urandom());
    cur_en = 32'h0; wr(5'h14, cur_en);
    rdreg(5'h00, rd); chk("R2 func", rd, cur_func);
    rdreg(5'h04, rd); chk("R2 dir", rd, cur_dir);
    rdreg(5'h0C, rd); chk("R2 level", rd, cur_lvl);
    wr(5'h15, 32'hFFFF_FFFF);
    rdreg(5'h14, rd); chk("R2 misaligned ignored", rd, cur_en);

    // R3 R8 R9: pad muxing under random patterns
    for (int k = 0; k < 24; k++) begin
      cur_func = (k == 0) ? 32'hFFFF_C000 : (k == 1) ? 32'hFFFF_FFFF : $urandom();
      cur_dir  = $urandom(); cur_dout = $urandom();
      alt_tx   = $urandom();
      wr(5'h00, cur_func); wr(5'h04, cur_dir); wr(5'h08, cur_dout);
      #1;
      chk("R3 R8 R9 pad_oe", pad_oe, exp_oe(cur_func, cur_dir));
      chk("R3 R8 R9 pad_out", pad_out, exp_out(cur_func, cur_dout, alt_tx));
    end
    wr(5'h00, 32'h0);
    #1;
    chk("R3 gpio oe", pad_oe, cur_dir);
    chk("R3 gpio out", pad_out, cur_dout);

    // R4 R5 R6 R7 R10: random level / pin / clear sequences
    for (int k = 0; k < 30; k++) begin
      set_level($urandom());
      set_pin($urandom());
      rdreg(5'h08, rd); chk("R4 data readback", rd, cur_pin);
      chk("R10 alt_rx", alt_rx, cur_pin);
      rdreg(5'h10, rd); chk("R5 sticky status", rd, exp_st);
      cur_en = $urandom() & $urandom();
      wr(5'h14, cur_en);
      clear_st($urandom());
      rdreg(5'h10, rd); chk("R6 clear", rd, exp_st);
      wait_cyc(2);
      chk("R7 nmi", {31'd0, nmi_o}, {31'd0, |(exp_st & cur_en)});
    end

    // R6: set wins over clear, then full clear with no match
    set_level(cur_pin);
    clear_st(32'hFFFF_FFFF);
    rdreg(5'h10, rd); chk("R6 set wins", rd, 32'hFFFF_FFFF);
    set_level(~cur_pin);
    clear_st(32'hFFFF_FFFF);
    rdreg(5'h10, rd); chk("R6 full clear", rd, 32'h0);
    clear_st(32'h0);
    rdreg(5'h10, rd); chk("R6 zero write keeps", rd, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF);
    wait_cyc(2);
    chk("R7 nmi low when clean", {31'd0, nmi_o}, 32'h0);
    set_pin(cur_pin ^ 32'h0000_0100);
    wait_cyc(1);
    chk("R7 nmi on new match", {31'd0, nmi_o}, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule